// File: doc/BRIEF.md
# SD Command Issue Sequencer

This block issues one command at a time to an SD card on behalf of software and captures the card's reply. Software loads a 32-bit argument and then a 16-bit command word. Writing the command word with its start flag set launches a request on the card-side port. The request carries the 6-bit command index and the argument. The card side answers with a response valid strobe, a byte length and up to 16 bytes. The block checks the reported length against the response type that the command asked for. It then lays the bytes out into four 32-bit response words that software can read.

If the length is wrong, the block sets a fail flag in the command word and a command-timeout bit in the status word. If the card stays silent for `TIMEOUT_CYCLES` cycles, the block treats that as a reply of zero bytes. When a busy-wait command completes cleanly and the busy-interrupt enable in the configuration word is on, a busy-complete status bit is raised. Status bits are cleared by writing ones to them.

Register offsets: command 0x00, argument 0x04, response words 0 to 3 at 0x10, 0x14, 0x18 and 0x1C, status 0x20, configuration 0x24. Reads are combinational and have no side effects.

Top module: `sd_cmd_seq`

## Requirements
- R1: After reset, the command, status, configuration, argument and all response words read zero, and both `busy` and `card_req` are low.
- R2: A write to 0x00 with bit 15 set while idle raises `busy` and `card_req` on the next cycle. `card_index` then equals bits 5:0 of the written word, and `card_arg` equals the argument register.
- R3: When the card's reply is accepted, `busy` and `card_req` fall on the next cycle, and bit 15 of the command word reads back as 0.
- R4: A 4-byte reply to a command that expects a short response (bit 10 clear, bit 9 clear) is placed big-endian into word 0, with byte 0 as the most significant byte. Words 1 to 3 read zero.
- R5: A 16-byte reply is placed so that word k holds bytes 12-4k through 15-4k, assembled big-endian. So word 0 holds bytes 12..15 and word 3 holds bytes 0..3.
- R6: A reply length error sets command bit 14 and status bit 6 and leaves the response words unchanged. The block is expecting a response when bit 10 is clear; the errors are a 0-byte reply, a 4-byte reply when bit 9 asks for a long one, and any length other than 4 or 16.
- R7: With command bit 10 set, a reply of any length completes without error and leaves the response words unchanged.
- R8: Status bit 10 is set when a command with bit 11 set completes without error and configuration bit 10 is set. It is not set when configuration bit 10 is clear.
- R9: A write to the command register while `busy` is high is ignored. The command word does not change and no second request is issued.
- R10: If no reply arrives within `TIMEOUT_CYCLES` cycles of the request, the command completes as a 0-byte reply.
- R11: Writing the status register clears exactly the bits written as 1.
- R12: The argument register reads back its written value. Writes to the response word offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| card_req | output | 1 | Request to the card is pending |
| card_index | output | 6 | Command index sent to the card |
| card_arg | output | 32 | Command argument sent to the card |
| card_rsp_valid | input | 1 | Card reply present this cycle |
| card_rsp_len | input | LEN_W | Reply length in bytes |
| card_rsp_data | input | 128 | Reply bytes, byte k in bits 8k+7:8k |
| busy | output | 1 | A command is in flight |

## Verification
A wrong sequencer state shows at once on `busy` and `card_req`. A request that never ends, or one that restarts while busy, can be seen within one cycle of the stimulus. A wrong length decision shows one cycle after the reply strobe, in command bit 14 and status bit 6. A wrong byte or word placement shows in the response words read back on the same cycle. A faulty timeout counter moves the completion edge away from `TIMEOUT_CYCLES` cycles after the request. The bench brackets that edge.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
   localparam int REG_W = 32;
   localparam int RSP_WORDS = 4;
   localparam int RSP_BYTES = 16;

   localparam logic [7:0] OFF_CMD  = 8'h00;
   localparam logic [7:0] OFF_ARG  = 8'h04;
   localparam logic [7:0] OFF_RSP0 = 8'h10;
   localparam logic [7:0] OFF_STAT = 8'h20;
   localparam logic [7:0] OFF_CFG  = 8'h24;

   localparam int CB_START   = 15;
   localparam int CB_FAIL    = 14;
   localparam int CB_BUSYW   = 11;
   localparam int CB_NORSP   = 10;
   localparam int CB_LONG    = 9;

   localparam int SB_BUSYIRQ = 10;
   localparam int SB_TMO     = 6;

   localparam int FB_BUSYEN  = 10;

   typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} seq_state_t;
endpackage

// File: rtl/sdc_issue_fsm.sv
module sdc_issue_fsm #(
   parameter int TIMEOUT_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic rsp_valid_i,
   output logic busy_o,
   output logic done_o,
   output logic timed_out_o
);
   import sdc_pkg::*;

   localparam int CNT_W = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

   initial begin
      assert (TIMEOUT_CYCLES >= 2) else $error("TIMEOUT_CYCLES must be at least 2");
   end

   seq_state_t state_q;
   logic [CNT_W-1:0] cnt_q;
   logic expire;

   assign busy_o      = (state_q == ST_WAIT);
   assign expire      = busy_o && (cnt_q == LAST);
   assign done_o      = busy_o && (rsp_valid_i || expire);
   assign timed_out_o = expire && !rsp_valid_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start_i) begin
               state_q <= ST_WAIT;
               cnt_q   <= '0;
            end
            ST_WAIT: if (done_o) state_q <= ST_IDLE;
                     else        cnt_q   <= cnt_q + 1'b1;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   assert_timeout_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
      timed_out_o |=> !busy_o);
endmodule

// File: rtl/sdc_rsp_pack.sv
module sdc_rsp_pack #(
   parameter int LEN_W = 5
) (
   input  logic [LEN_W-1:0]                  len_i,
   input  logic [sdc_pkg::RSP_BYTES*8-1:0]   bytes_i,
   input  logic                              no_rsp_i,
   input  logic                              long_i,
   output logic                              err_o,
   output logic                              load_o,
   output logic [sdc_pkg::RSP_WORDS-1:0][sdc_pkg::REG_W-1:0] words_o
);
   import sdc_pkg::*;

   initial begin
      assert (LEN_W >= 5) else $error("LEN_W must hold 16");
   end

   logic len4, len16;
   assign len4  = (len_i == LEN_W'(4));
   assign len16 = (len_i == LEN_W'(16));

   assign err_o  = !no_rsp_i && !(len16 || (len4 && !long_i));
   assign load_o = !no_rsp_i && !err_o;

   for (genvar w = 0; w < RSP_WORDS; w++) begin : g_word
      logic [REG_W-1:0] long_word;
      logic [REG_W-1:0] short_word;
      for (genvar b = 0; b < 4; b++) begin : g_byte
         localparam int SRC_L = 4*(RSP_WORDS-1-w) + b;
         assign long_word[REG_W-1-8*b -: 8] = bytes_i[8*SRC_L +: 8];
         if (w == 0) begin : g_s0
            assign short_word[REG_W-1-8*b -: 8] = bytes_i[8*b +: 8];
         end else begin : g_sz
            assign short_word[REG_W-1-8*b -: 8] = 8'h00;
         end
      end
      assign words_o[w] = len16 ? long_word : short_word;
   end
endmodule

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq #(
   parameter int ADDR_W         = 8,
   parameter int LEN_W          = 5,
   parameter int TIMEOUT_CYCLES = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   output logic                card_req,
   output logic [5:0]          card_index,
   output logic [31:0]         card_arg,
   input  logic                card_rsp_valid,
   input  logic [LEN_W-1:0]    card_rsp_len,
   input  logic [127:0]        card_rsp_data,
   output logic                busy
);
   import sdc_pkg::*;

   initial begin
      assert (ADDR_W >= 6) else $error("ADDR_W must reach 0x24");
   end

   localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
   localparam logic [ADDR_W-1:0] A_ARG  = ADDR_W'(OFF_ARG);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG);

   logic [15:0] cmd_q;
   logic [31:0] arg_q, stat_q, cfg_q;
   logic [RSP_WORDS-1:0][REG_W-1:0] rsp_q;

   logic start, done, timed_out, err, load;
   logic [LEN_W-1:0] eff_len;
   logic [RSP_WORDS-1:0][REG_W-1:0] packed_words;
   logic [31:0] stat_set;

   assign start = reg_wr && (reg_addr == A_CMD) && !busy && reg_wdata[CB_START];

   sdc_issue_fsm #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start_i(start), .rsp_valid_i(card_rsp_valid),
      .busy_o(busy), .done_o(done), .timed_out_o(timed_out)
   );

   assign eff_len = timed_out ? '0 : card_rsp_len;

   sdc_rsp_pack #(.LEN_W(LEN_W)) u_pack (
      .len_i(eff_len), .bytes_i(card_rsp_data),
      .no_rsp_i(cmd_q[CB_NORSP]), .long_i(cmd_q[CB_LONG]),
      .err_o(err), .load_o(load), .words_o(packed_words)
   );

   assign card_req   = busy;
   assign card_index = cmd_q[5:0];
   assign card_arg   = arg_q;

   always_comb begin
      stat_set = '0;
      if (done) begin
         stat_set[SB_TMO] = err;
         stat_set[SB_BUSYIRQ] = !err && cmd_q[CB_BUSYW] && cfg_q[FB_BUSYEN];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         arg_q  <= '0;
         stat_q <= '0;
         cfg_q  <= '0;
         rsp_q  <= '0;
      end else begin
         if (reg_wr && reg_addr == A_CMD && !busy) cmd_q <= reg_wdata[15:0];
         if (reg_wr && reg_addr == A_ARG) arg_q <= reg_wdata;
         if (reg_wr && reg_addr == A_CFG) cfg_q <= reg_wdata;
         stat_q <= (reg_wr && reg_addr == A_STAT) ? ((stat_q & ~reg_wdata) | stat_set)
                                                  : (stat_q | stat_set);
         if (done) begin
            cmd_q[CB_START] <= 1'b0;
            cmd_q[CB_FAIL]  <= err;
            if (load) rsp_q <= packed_words;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if      (reg_addr == A_CMD)  reg_rdata = {16'h0, cmd_q};
      else if (reg_addr == A_ARG)  reg_rdata = arg_q;
      else if (reg_addr == A_STAT) reg_rdata = stat_q;
      else if (reg_addr == A_CFG)  reg_rdata = cfg_q;
      else begin
         for (int w = 0; w < RSP_WORDS; w++)
            if (reg_addr == ADDR_W'(OFF_RSP0) + ADDR_W'(4*w)) reg_rdata = rsp_q[w];
      end
   end

   assert_fail_flags_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_q[CB_FAIL]) |-> stat_q[SB_TMO]);

   assert_start_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !cmd_q[CB_START]);

   assert_cmd_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cmd_q));

   assert_busyirq_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[SB_BUSYIRQ]) |-> cfg_q[FB_BUSYEN]);
endmodule

// File: tb/tb_sd_cmd_seq.sv
module tb_sd_cmd_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [7:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic card_req;
   logic [5:0] card_index;
   logic [31:0] card_arg;
   logic card_rsp_valid = 1'b0;
   logic [4:0] card_rsp_len = '0;
   logic [127:0] card_rsp_data;
   logic busy;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   sd_cmd_seq dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .card_req(card_req),
      .card_index(card_index), .card_arg(card_arg),
      .card_rsp_valid(card_rsp_valid), .card_rsp_len(card_rsp_len),
      .card_rsp_data(card_rsp_data), .busy(busy)
   );

   initial begin
      for (int k = 0; k < 16; k++) card_rsp_data[8*k +: 8] = 8'hA0 + 8'(k);
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         n_fail = n_fail + 1;
         n_chk = n_chk + 1;
         $display("FAIL watchdog: act=expired exp=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic reply(input logic [4:0] len);
      card_rsp_valid = 1'b1; card_rsp_len = len;
      @(negedge clk);
      card_rsp_valid = 1'b0;
   endtask

   task automatic clear_rsp_words();
      logic [31:0] v;
      wr(8'h00, 32'h0000_8000);
      reply(5'd16);
      rd(8'h10, v);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      @(negedge clk);
      chk("R1 busy", {31'h0, busy}, 0);
      chk("R1 req", {31'h0, card_req}, 0);
      rd(8'h00, v); chk("R1 cmd", v, 0);
      rd(8'h20, v); chk("R1 status", v, 0);
      rd(8'h04, v); chk("R1 arg", v, 0);
      for (int w = 0; w < 4; w++) begin
         rd(8'h10 + 8'(4*w), v); chk("R1 rsp", v, 0);
      end
   endtask

   task automatic t_short();
      logic [31:0] v;
      wr(8'h04, 32'hDEAD_BEEF);
      wr(8'h00, 32'h0000_8011);
      chk("R2 busy", {31'h0, busy}, 1);
      chk("R2 req", {31'h0, card_req}, 1);
      chk("R2 index", {26'h0, card_index}, 32'h11);
      chk("R2 arg", card_arg, 32'hDEAD_BEEF);
      reply(5'd4);
      chk("R3 busy low", {31'h0, busy}, 0);
      chk("R3 req low", {31'h0, card_req}, 0);
      rd(8'h00, v); chk("R3 start cleared", v, 32'h0000_0011);
      rd(8'h10, v); chk("R4 word0", v, 32'hA0A1A2A3);
      rd(8'h14, v); chk("R4 word1", v, 0);
      rd(8'h1C, v); chk("R4 word3", v, 0);
   endtask

   task automatic t_long();
      logic [31:0] v;
      wr(8'h00, 32'h0000_8202);
      reply(5'd16);
      rd(8'h10, v); chk("R5 word0", v, 32'hACADAEAF);
      rd(8'h14, v); chk("R5 word1", v, 32'hA8A9AAAB);
      rd(8'h18, v); chk("R5 word2", v, 32'hA4A5A6A7);
      rd(8'h1C, v); chk("R5 word3", v, 32'hA0A1A2A3);
   endtask

   task automatic t_len_err(input logic [15:0] cmd, input logic [4:0] len);
      logic [31:0] v;
      wr(8'h00, {16'h0, cmd});
      reply(len);
      rd(8'h00, v); chk("R6 fail flag", v & 32'h4000, 32'h4000);
      rd(8'h20, v); chk("R6 timeout status", v & 32'h40, 32'h40);
      rd(8'h10, v); chk("R6 rsp kept", v, 32'hACADAEAF);
      wr(8'h20, 32'h40);
   endtask

   task automatic t_noresp();
      logic [31:0] v;
      wr(8'h00, 32'h0000_8400);
      reply(5'd4);
      rd(8'h00, v); chk("R7 no fail", v & 32'h4000, 0);
      rd(8'h20, v); chk("R7 no status", v, 0);
      rd(8'h10, v); chk("R7 rsp kept", v, 32'hACADAEAF);
   endtask

   task automatic t_busywait();
      logic [31:0] v;
      wr(8'h24, 32'h0);
      wr(8'h00, 32'h0000_8800);
      reply(5'd4);
      rd(8'h20, v); chk("R8 irq without enable", v & 32'h400, 0);
      wr(8'h24, 32'h400);
      wr(8'h00, 32'h0000_8800);
      reply(5'd4);
      rd(8'h20, v); chk("R8 irq with enable", v & 32'h400, 32'h400);
      wr(8'h20, 32'h0);
      rd(8'h20, v); chk("R11 zero write keeps", v, 32'h400);
      wr(8'h20, 32'h400);
      rd(8'h20, v); chk("R11 one clears", v, 0);
   endtask

   task automatic t_busy_ignore();
      logic [31:0] v;
      wr(8'h00, 32'h0000_8005);
      wr(8'h00, 32'h0000_8233);
      rd(8'h00, v); chk("R9 cmd unchanged", v, 32'h0000_8005);
      chk("R9 index unchanged", {26'h0, card_index}, 32'h05);
      reply(5'd4);
      @(negedge clk);
      chk("R9 no second request", {31'h0, busy}, 0);
      rd(8'h10, v); chk("R9 short layout kept", v, 32'hA0A1A2A3);
   endtask

   task automatic t_timeout();
      logic [31:0] v;
      wr(8'h00, 32'h0000_8001);
      repeat (58) @(negedge clk);
      chk("R10 still waiting", {31'h0, busy}, 1);
      repeat (10) @(negedge clk);
      chk("R10 expired", {31'h0, busy}, 0);
      rd(8'h00, v); chk("R10 fail flag", v & 32'h4000, 32'h4000);
      rd(8'h20, v); chk("R10 status", v & 32'h40, 32'h40);
      wr(8'h20, 32'hFFFF_FFFF);
   endtask

   task automatic t_regs();
      logic [31:0] v;
      wr(8'h04, 32'h1234_5678);
      rd(8'h04, v); chk("R12 arg readback", v, 32'h1234_5678);
      rd(8'h18, v);
      wr(8'h18, 32'hFFFF_0000);
      begin
         logic [31:0] w;
         rd(8'h18, w); chk("R12 rsp read-only", w, v);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_short();
      t_long();
      t_len_err(16'h8000, 5'd0);
      t_len_err(16'h8200, 5'd4);
      t_len_err(16'h8000, 5'd7);
      t_noresp();
      t_busywait();
      t_long();
      t_busy_ignore();
      t_timeout();
      t_regs();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule